// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block paces DRAM refresh for a memory controller. A rate timer, whose interval is chosen by a small select field, produces a refresh request at every expiry. Requests wait in a four-deep counting queue. The queue is served only while the rest of the controller has nothing else to do. Once the queue is full, refresh jumps ahead of every other memory request. Each served request runs one CAS-before-RAS cycle on every populated row in turn. Rows without memory are skipped. A row counts as populated when its boundary register differs from the one below it.

The block also handles self refresh. While self refresh is requested, every pending request is drained first, whatever other traffic is waiting. Then all populated rows are held in CAS-before-RAS self refresh until the request drops. On exit the queue is emptied and the rate timer starts a fresh full interval. The DRAM sequencer gives way while `ref_own` is high, and it sees `ref_done` once for every request served.

Top module: `rfsh_sched`

## Requirements
- R1: With refresh enabled, a request is queued every `BASE << rate_sel` clocks (16, 32, 64 or 128 clocks for rate_sel 0 to 3 at default parameters). The first request is counted BASE<<rate_sel clocks after enable rises. `rate_sel` must be changed only while refresh is disabled, and the next enable uses the new interval.
- R2: The queue holds at most four requests. A request produced while four are pending is dropped.
- R3: A pending request starts service only in a clock where `seq_busy` is low and either `other_pend` is low, the queue is full, or `sr_req` is high. While `seq_busy` is high, no refresh service starts.
- R4: `ref_urgent` is high exactly while four requests are pending. A full queue is served on the next clock after `seq_busy` is low, even with `other_pend` high.
- R5: Row i is populated when its boundary byte `row_bnd[8i+7:8i]` differs from row i-1's byte. Row 0 is compared with zero. Each served request gives exactly one RAS strobe on each populated row and none on the other rows. A request with no populated rows still completes.
- R6: In a refresh cycle, `cas_en[i]` rises one clock before `ras_en[i]`. `ras_en[i]` stays high for RAS_CYC clocks (3 by default), and both strobes fall together. At most one row is strobed at a time.
- R7: `ref_own` is high while a request is being served. `ref_done` is a one-clock pulse that follows each served request.
- R8: While `sr_req` is high, pending requests are served regardless of `other_pend`. Self refresh is entered only once the queue is empty.
- R9: In self refresh, `sr_active` is high. `cas_en` equals the populated-row mask one clock before `ras_en` joins it, and both then stay at the mask until `sr_req` drops.
- R10: When `sr_req` drops, all strobes and `sr_active` fall on the next clock and the queue is cleared. With refresh enabled, the next request is counted a full interval after exit.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rfsh_en | input | 1 | Enables the refresh rate timer |
| rate_sel | input | RATE_W | Interval select, period BASE << rate_sel |
| row_bnd | input | ROWS*BND_W | Row boundary values, row i in bits [BND_W*i +: BND_W] |
| other_pend | input | 1 | Another memory request is waiting |
| seq_busy | input | 1 | DRAM sequencer is mid-access and cannot yield |
| sr_req | input | 1 | Self refresh requested (level) |
| ref_own | output | 1 | Refresh owns the DRAM, sequencer must hold off |
| ref_done | output | 1 | One-clock pulse per served request |
| ref_urgent | output | 1 | Queue full, refresh has top priority |
| sr_active | output | 1 | Self refresh strobes are applied |
| ras_en | output | ROWS | Per-row RAS strobe, active high |
| cas_en | output | ROWS | Per-row CAS strobe, active high |

## Verification
The hardest state to reach from the ports is a saturated queue that keeps receiving timer expiries. Normally requests are served almost as fast as they arrive. The stimulus holds `seq_busy` high while the timer runs for eight intervals, so the queue fills and the extra expiries are dropped. It then lets exactly one forced service through under `other_pend`, and counts `ref_done` pulses to show that exactly four requests were kept. Self-refresh drain is reached the same way: the queue is pre-loaded behind `seq_busy`, then `sr_req` is raised with `other_pend` still high.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CAS    = 3'd1,
        ST_RAS    = 3'd2,
        ST_GAP    = 3'd3,
        ST_SRCAS  = 3'd4,
        ST_SRHOLD = 3'd5
    } rfsh_state_e;

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int BASE   = 16,
    parameter int RATE_W = 2,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tick
);

    logic [TMR_W-1:0] tmr_d, tmr_q;
    logic [TMR_W-1:0] reload;

    always_comb begin
        reload = (TMR_W'(BASE) << rate_sel) - TMR_W'(1);
        tick   = run && (tmr_q == '0);
        if (!run || tmr_q == '0) tmr_d = reload;
        else                     tmr_d = tmr_q - TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= TMR_W'(BASE - 1);
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/rfsh_queue.sv
module rfsh_queue #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic clr,
    output logic nonempty,
    output logic full
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + {{CNT_W{1'b0}}, push} - {{CNT_W{1'b0}}, pop};
        if (clr)                          cnt_d = '0;
        else if (sum > (CNT_W+1)'(DEPTH)) cnt_d = CNT_W'(DEPTH);
        else                              cnt_d = sum[CNT_W-1:0];
    end

    assign nonempty = (cnt_q != '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rfsh_popmask.sv
module rfsh_popmask #(
    parameter int ROWS  = 4,
    parameter int BND_W = 8
) (
    input  logic [ROWS*BND_W-1:0] row_bnd,
    output logic [ROWS-1:0]       pop_mask
);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        if (i == 0) begin : g_first
            assign pop_mask[i] = (row_bnd[BND_W-1:0] != '0);
        end else begin : g_rest
            assign pop_mask[i] = (row_bnd[BND_W*i +: BND_W] != row_bnd[BND_W*(i-1) +: BND_W]);
        end
    end

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int ROWS    = 4,
    parameter int BND_W   = 8,
    parameter int RATE_W  = 2,
    parameter int BASE    = 16,
    parameter int DEPTH   = 4,
    parameter int RAS_CYC = 3,
    parameter int PRE_CYC = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rfsh_en,
    input  logic [RATE_W-1:0]     rate_sel,
    input  logic [ROWS*BND_W-1:0] row_bnd,
    input  logic                  other_pend,
    input  logic                  seq_busy,
    input  logic                  sr_req,
    output logic                  ref_own,
    output logic                  ref_done,
    output logic                  ref_urgent,
    output logic                  sr_active,
    output logic [ROWS-1:0]       ras_en,
    output logic [ROWS-1:0]       cas_en
);

    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int MAXC  = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
    localparam int CYC_W = (MAXC > 1) ? $clog2(MAXC + 1) : 1;
    localparam int TMR_W = $clog2(BASE) + (1 << RATE_W);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rfsh_state_e      st;
        logic [ROW_W-1:0] ptr;
        logic [CYC_W-1:0] cyc;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic            tick, q_pop, q_clr, q_nonempty, q_full, tmr_run;
    logic [ROWS-1:0] pop_mask;
    logic [ROWS-1:0] row_sel;
    logic [ROW_W:0]  hit;
    logic            in_sr, start_ref;

    // lowest populated row at or above 'from'; MSB flags a hit
    function automatic logic [ROW_W:0] find_row(input logic [ROWS-1:0] m, input int from);
        logic [ROW_W:0] r;
        r = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, ROW_W'(i)};
        end
        return r;
    endfunction

    rfsh_popmask #(.ROWS(ROWS), .BND_W(BND_W)) u_mask (
        .row_bnd (row_bnd),
        .pop_mask(pop_mask)
    );

    rfsh_timer #(.BASE(BASE), .RATE_W(RATE_W), .TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .rate_sel(rate_sel),
        .tick    (tick)
    );

    rfsh_queue #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (tick),
        .pop     (q_pop),
        .clr     (q_clr),
        .nonempty(q_nonempty),
        .full    (q_full)
    );

    assign in_sr     = (ctl_q.st == ST_SRCAS) || (ctl_q.st == ST_SRHOLD);
    assign tmr_run   = rfsh_en && !in_sr;
    assign start_ref = q_nonempty && !seq_busy && (!other_pend || q_full || sr_req);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        q_pop      = 1'b0;
        q_clr      = 1'b0;
        hit        = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_ref) begin
                    hit = find_row(pop_mask, 0);
                    if (hit[ROW_W]) begin
                        ctl_d.st  = ST_CAS;
                        ctl_d.ptr = hit[ROW_W-1:0];
                    end else begin
                        ctl_d.st  = ST_GAP;
                        ctl_d.ptr = ROW_W'(ROWS - 1);
                        ctl_d.cyc = CYC_W'(PRE_CYC - 1);
                    end
                end else if (sr_req && !q_nonempty && !seq_busy) begin
                    ctl_d.st = ST_SRCAS;
                end
            end
            ST_CAS: begin
                ctl_d.st  = ST_RAS;
                ctl_d.cyc = CYC_W'(RAS_CYC - 1);
            end
            ST_RAS: begin
                if (ctl_q.cyc == '0) begin
                    ctl_d.st  = ST_GAP;
                    ctl_d.cyc = CYC_W'(PRE_CYC - 1);
                end else begin
                    ctl_d.cyc = ctl_q.cyc - CYC_W'(1);
                end
            end
            ST_GAP: begin
                if (ctl_q.cyc == '0) begin
                    hit = find_row(pop_mask, int'(ctl_q.ptr) + 1);
                    if (hit[ROW_W]) begin
                        ctl_d.st  = ST_CAS;
                        ctl_d.ptr = hit[ROW_W-1:0];
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        q_pop      = 1'b1;
                    end
                end else begin
                    ctl_d.cyc = ctl_q.cyc - CYC_W'(1);
                end
            end
            ST_SRCAS: begin
                if (!sr_req) begin
                    ctl_d.st = ST_IDLE;
                    q_clr    = 1'b1;
                end else begin
                    ctl_d.st = ST_SRHOLD;
                end
            end
            ST_SRHOLD: begin
                if (!sr_req) begin
                    ctl_d.st = ST_IDLE;
                    q_clr    = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.ptr  <= '0;
            ctl_q.cyc  <= '0;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign row_sel = ROWS'(1) << ctl_q.ptr;

    always_comb begin
        cas_en = '0;
        ras_en = '0;
        case (ctl_q.st)
            ST_CAS:    cas_en = row_sel;
            ST_RAS:    begin cas_en = row_sel;  ras_en = row_sel;  end
            ST_SRCAS:  cas_en = pop_mask;
            ST_SRHOLD: begin cas_en = pop_mask; ras_en = pop_mask; end
            default:   ;
        endcase
    end

    assign ref_own    = (ctl_q.st == ST_CAS) || (ctl_q.st == ST_RAS) || (ctl_q.st == ST_GAP);
    assign ref_done   = ctl_q.done;
    assign ref_urgent = q_full;
    assign sr_active  = in_sr;

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            seq_busy,
    input logic            ref_own,
    input logic            ref_done,
    input logic            ref_urgent,
    input logic            sr_active,
    input logic [ROWS-1:0] ras_en,
    input logic [ROWS-1:0] cas_en
);

    // R6
    cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ras_en & ~$past(ras_en) & ~$past(cas_en)) == '0));

    // R6
    one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_active |-> $onehot0(cas_en));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    // R7
    done_after_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |-> $past(ref_own));

    // R4
    urgent_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent && !ref_own && !seq_busy && !sr_active) |=> ref_own);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_own && !sr_active && seq_busy) |=> !ref_own);

    // R9
    sr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_active && $past(sr_active)) |-> (ras_en == cas_en));

    // R9
    sr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sr_active) |-> (ras_en == '0));

endmodule

bind rfsh_sched rfsh_sched_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_busy  (seq_busy),
    .ref_own   (ref_own),
    .ref_done  (ref_done),
    .ref_urgent(ref_urgent),
    .sr_active (sr_active),
    .ras_en    (ras_en),
    .cas_en    (cas_en)
);

// File: tb/rfsh_sched_test.sv
`timescale 1ns/1ps
module rfsh_sched_test;

    localparam int ROWS = 4;
    localparam int RAS_CYC = 3;
    localparam int BASE = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rfsh_en = 1'b0;
    logic [1:0]      rate_sel = 2'd0;
    logic [31:0]     row_bnd = 32'h20181008;
    logic            other_pend = 1'b0;
    logic            seq_busy = 1'b0;
    logic            sr_req = 1'b0;
    logic            ref_own, ref_done, ref_urgent, sr_active;
    logic [ROWS-1:0] ras_en, cas_en;

    int n_run = 0;
    int n_fail = 0;

    // {row_bnd (row3..row0 bytes), expected populated mask}
    localparam logic [35:0] VECS [5] = '{
        36'h20181008F,
        36'h20101000A,
        36'h040404041,
        36'h000000000,
        36'h080000008
    };

    rfsh_sched uut (
        .clk(clk), .rst_n(rst_n), .rfsh_en(rfsh_en), .rate_sel(rate_sel),
        .row_bnd(row_bnd), .other_pend(other_pend), .seq_busy(seq_busy),
        .sr_req(sr_req), .ref_own(ref_own), .ref_done(ref_done),
        .ref_urgent(ref_urgent), .sr_active(sr_active),
        .ras_en(ras_en), .cas_en(cas_en)
    );

    always #2.5 clk = ~clk;

    // strobe monitor
    bit              mon_clr = 1'b0;
    int              ras_cnt [ROWS];
    int              rlen [ROWS];
    int              done_cnt = 0;
    int              viol = 0;
    logic [ROWS-1:0] pr = '0, pc = '0;
    logic            psr = 1'b0;

    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < ROWS; i++) begin ras_cnt[i] = 0; rlen[i] = 0; end
            done_cnt = 0;
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                if (ras_en[i] && !pr[i]) begin
                    if (!pc[i]) viol++;
                    ras_cnt[i]++;
                    rlen[i] = 1;
                end else if (ras_en[i]) begin
                    rlen[i]++;
                end else if (pr[i]) begin
                    if (!psr && rlen[i] != RAS_CYC) viol++;
                    if (cas_en[i]) viol++;
                end
            end
            if (ref_done) done_cnt++;
        end
        pr  = ras_en;
        pc  = cas_en;
        psr = sr_active;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        step(2);
        mon_clr = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int k = 0; k < 4000 && q < 40; k++) begin
            step(1);
            if (ref_own) q = 0; else q++;
        end
        #1;
    endtask

    initial begin
        for (int i = 0; i < ROWS; i++) begin ras_cnt[i] = 0; rlen[i] = 0; end
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(4);
        // R11 reset state
        check({ref_own, ref_done, ref_urgent, sr_active} == 4'b0, "R11 flags", ref_own, 0);
        check(ras_en == '0 && cas_en == '0, "R11 strobes", int'(ras_en | cas_en), 0);
        rst_n = 1'b1;
        step(2);

        // R5 R6 R7: vector table
        foreach (VECS[v]) begin
            row_bnd = VECS[v][35:4];
            clear_mon();
            rfsh_en = 1'b1;
            step(60);
            rfsh_en = 1'b0;
            wait_quiet();
            check(done_cnt > 0, "R7 done pulses", done_cnt, 1);
            for (int i = 0; i < ROWS; i++)
                check(ras_cnt[i] == done_cnt * int'(VECS[v][i]), "R5 row refresh count",
                      ras_cnt[i], done_cnt * int'(VECS[v][i]));
        end
        row_bnd = 32'h20181008;

        // R1 rate 0, R2 saturation, R3 busy gating, R4 forced service
        seq_busy = 1'b1;
        rate_sel = 2'd0;
        step(1);
        rfsh_en = 1'b1;
        step(4 * BASE - 1);
        check(ref_urgent == 1'b0, "R1 rate0 not yet full", ref_urgent, 0);
        step(1);
        check(ref_urgent == 1'b1, "R1 rate0 full after 4 periods", ref_urgent, 1);
        step(4 * BASE);
        check(ref_urgent == 1'b1, "R2 stays full", ref_urgent, 1);
        check(ref_own == 1'b0, "R3 busy blocks service", ref_own, 0);
        rfsh_en = 1'b0;
        clear_mon();
        other_pend = 1'b1;
        seq_busy = 1'b0;
        step(60);
        #1;
        check(done_cnt == 1, "R4 forced service under other_pend", done_cnt, 1);
        check(ref_urgent == 1'b0, "R4 urgent drops below full", ref_urgent, 0);
        step(40);
        #1;
        check(done_cnt == 1, "R3 other_pend holds queue", done_cnt, 1);
        other_pend = 1'b0;
        wait_quiet();
        check(done_cnt == 4, "R2 excess requests dropped", done_cnt, 4);

        // R1 rate 2
        seq_busy = 1'b1;
        rate_sel = 2'd2;
        step(1);
        rfsh_en = 1'b1;
        step(4 * (BASE << 2) - 1);
        check(ref_urgent == 1'b0, "R1 rate2 not yet full", ref_urgent, 0);
        step(1);
        check(ref_urgent == 1'b1, "R1 rate2 full after 4 periods", ref_urgent, 1);
        rfsh_en = 1'b0;
        seq_busy = 1'b0;
        wait_quiet();
        rate_sel = 2'd0;
        step(2);

        // R8 R9 R10 self refresh
        row_bnd = 32'h20101000;
        seq_busy = 1'b1;
        step(1);
        rfsh_en = 1'b1;
        step(40);
        rfsh_en = 1'b0;
        clear_mon();
        sr_req = 1'b1;
        other_pend = 1'b1;
        seq_busy = 1'b0;
        for (int k = 0; k < 300 && !sr_active; k++) step(1);
        #1;
        check(sr_active == 1'b1, "R9 self refresh entered", sr_active, 1);
        check(done_cnt == 2, "R8 queue drained before entry", done_cnt, 2);
        check(cas_en == 4'hA && ras_en == 4'h0, "R9 CAS leads on populated rows",
              int'({ras_en, cas_en}), 8'h0A);
        step(2);
        check(cas_en == 4'hA && ras_en == 4'hA, "R9 hold strobes", int'({ras_en, cas_en}), 8'hAA);
        step(20);
        check(sr_active == 1'b1 && ras_en == 4'hA, "R9 held while requested", int'(ras_en), 4'hA);
        rfsh_en = 1'b1;
        sr_req = 1'b0;
        other_pend = 1'b0;
        step(1);
        check(!sr_active && ras_en == '0 && cas_en == '0, "R10 strobes released",
              int'({ras_en, cas_en}), 0);
        step(BASE - 1);
        check(ref_own == 1'b0, "R10 no refresh before full interval", ref_own, 0);
        step(2);
        check(ref_own == 1'b1, "R10 timer restarted", ref_own, 1);
        rfsh_en = 1'b0;
        wait_quiet();
        check(viol == 0, "R6 CBR strobe timing", viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule